// File: doc/BRIEF.md
# External Interrupt Request Controller

This block serves one active-low external interrupt pin. The pin passes through a two-stage synchronizer, and a high-to-low transition of the synchronized level records a pending request in a latch. The latch drives the interrupt request toward the priority logic unless the mask bit is set. A masked request stays latched and appears as soon as the mask is cleared. The synchronized pin level is also provided on its own output, so the CPU can run its branch-on-pin tests.

There are two trigger modes. In edge mode any acknowledge removes the request. An acknowledge is either a one-cycle vector-fetch strobe or a software write of 1 to the acknowledge bit. In edge-and-level mode the request is removed only after two events have both happened, in either order: an acknowledge, and the synchronized pin returning high. A single 8-bit control/status register is reached through a plain synchronous select/write-enable bus. Reset is asynchronous and active-low. Its release is synchronized inside the block.

Top module: `ext_irq_ctrl`

## Requirements
- R1: During reset and after its release, the register reads 0x00, `irq_req` is 0 and `pin_level` is 1. The internal reset is released on the second rising clock edge after `rst_n` goes high.
- R2: A pin value sampled at rising edge k that is low, following a high sample, sets the pending flag (register bit 3) at edge k+2.
- R3: `pin_level` shows the pin value sampled at edge k after edge k+1.
- R4: With the mode bit (bit 0) at 0, a vector fetch or a register write with bit 2 = 1 clears the pending flag even while the pin is low.
- R5: With the mode bit at 1 and the pin held low, an acknowledge leaves the flag set. The flag clears on the edge after the synchronized level turns high.
- R6: With the mode bit at 1 and the synchronized pin already high, an acknowledge clears the flag on its own edge.
- R7: With the mask bit (bit 1) at 1, `irq_req` is 0 and the pending flag is kept. With the mask at 0, `irq_req` equals the pending flag.
- R8: Register layout: bits 7..4 read 0, bit 3 is the read-only pending flag, bit 2 (acknowledge) always reads 0, bit 1 is the mask, bit 0 is the mode. `bus_rdata` is 0 when `bus_sel` is 0.
- R9: A register write with bit 2 = 0 does not change the pending flag.
- R10: A falling edge and an acknowledge in the same cycle leave the flag set.
- R11: Reset clears the pending flag and the mode bit while the pin is low.
- R12: In edge-and-level mode, an acknowledge made while nothing is pending is not remembered. A later request still needs its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| bus_sel | input | 1 | Register select |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| vec_fetch | input | 1 | One-cycle vector-fetch acknowledge strobe |
| irq_req | output | 1 | Unmasked pending request to priority logic |
| pin_level | output | 1 | Synchronized pin level |

## Verification
Two collisions matter: a newly detected falling edge arriving in the same cycle as an acknowledge, and an acknowledge arriving in the same cycle as the synchronized pin returning high. The bench provokes the first by timing a vector-fetch strobe so that it coincides with the edge at which the synchronizer reports the fall. It provokes the second by sending acknowledges before and after the pin is released in edge-and-level mode. A behavioural reference model advances on every clock, and its pending flag, request and read data are compared against the outputs each cycle. Directed checks add fixed expected values at the edges that matter.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W    = 8;
  localparam int PEND_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 0;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic       mask;
    trig_mode_e mode;
  } irq_ctl_t;
endpackage

// File: rtl/ext_irq_rst_sync.sv
module ext_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_pin_sync.sv
module ext_irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    stage_d[0] = pin_n;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    prev_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      stage_q <= stage_d;
      prev_q  <= prev_d;
    end
  end

  assign level = stage_q[STAGES-1];
  assign fall  = prev_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             pend,
  output logic [REG_W-1:0] rdata,
  output irq_ctl_t         ctl,
  output logic             sw_ack
);
  irq_ctl_t ctl_q;
  irq_ctl_t ctl_d;
  logic     wr_en;

  assign wr_en  = sel & we;
  assign sw_ack = wr_en & wdata[ACK_BIT];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.mask = wdata[MASK_BIT];
      ctl_d.mode = trig_mode_e'(wdata[MODE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '{mask: 1'b0, mode: TRIG_EDGE};
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[PEND_BIT] = pend;
      rdata[MASK_BIT] = ctl_q.mask;
      rdata[MODE_BIT] = ctl_q.mode;
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall,
  input  logic       level,
  input  logic       ack,
  input  trig_mode_e mode,
  output logic       pend
);
  logic pend_q, pend_d;
  logic seen_q, seen_d;
  logic clr;

  always_comb begin
    if (mode == TRIG_EDGE_LEVEL) clr = (ack | seen_q) & level;
    else                         clr = ack;
    if (fall)     pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
    else          pend_d = pend_q;
    seen_d = ~fall & pend_d & (mode == TRIG_EDGE_LEVEL) & (seen_q | ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      seen_q <= seen_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             vec_fetch,
  output logic             irq_req,
  output logic             pin_level
);
  logic     rst_sync_n;
  logic     sync_lvl;
  logic     fall;
  logic     sw_ack;
  logic     ack;
  logic     pend;
  irq_ctl_t ctl;

  ext_irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ext_irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_n(irq_pin_n),
    .level(sync_lvl), .fall(fall)
  );

  ext_irq_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .we(bus_we),
    .wdata(bus_wdata), .pend(pend), .rdata(bus_rdata),
    .ctl(ctl), .sw_ack(sw_ack)
  );

  assign ack = vec_fetch | sw_ack;

  ext_irq_latch u_latch (
    .clk(clk), .rst_n(rst_sync_n), .fall(fall), .level(sync_lvl),
    .ack(ack), .mode(ctl.mode), .pend(pend)
  );

  assign irq_req   = pend & ~ctl.mask;
  assign pin_level = sync_lvl;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       fall,
  input logic       sync_lvl,
  input logic       ack,
  input logic       pend,
  input logic       mask,
  input logic       mode,
  input logic       irq_req,
  input logic [7:0] bus_rdata
);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fall |=> pend);

  assert_edge_clear_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode && ack && !fall) |=> !pend);

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode && pend && !sync_lvl) |=> pend);

  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mask |-> !irq_req);

  assert_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mask && pend) |-> irq_req);

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rdata[7:4] == 4'h0) && !bus_rdata[2]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fall && ack) |=> pend);
endmodule

bind ext_irq_ctrl ext_irq_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .fall(fall), .sync_lvl(sync_lvl),
  .ack(ack), .pend(pend), .mask(ctl.mask), .mode(ctl.mode),
  .irq_req(irq_req), .bus_rdata(bus_rdata)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_pin_n;
  logic       bus_sel, bus_we, vec_fetch;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_req, pin_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_fetch(vec_fetch), .irq_req(irq_req), .pin_level(pin_level)
  );

  // behavioural reference model
  int  m_rcnt;
  bit  m_pend, m_seen, m_mask, m_mode;
  bit  m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rcnt = 0; m_pend = 0; m_seen = 0; m_mask = 0; m_mode = 0;
      m_s1 = 1; m_s2 = 1; m_s3 = 1;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      bit wr, ack, fell;
      wr   = bus_sel && bus_we;
      ack  = vec_fetch || (wr && bus_wdata[2]);
      fell = m_s3 && !m_s2;
      if (fell) begin
        m_pend = 1; m_seen = 0;
      end else if (m_pend) begin
        if (!m_mode) begin
          if (ack) m_pend = 0;
          m_seen = 0;
        end else if ((ack || m_seen) && m_s2) begin
          m_pend = 0; m_seen = 0;
        end else if (ack) begin
          m_seen = 1;
        end
      end
      if (wr) begin
        m_mask = bus_wdata[1];
        m_mode = bus_wdata[0];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_pin_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      logic [7:0] exp_rd;
      exp_rd = bus_sel ? {4'h0, m_pend, 1'b0, m_mask, m_mode} : 8'h00;
      chk(irq_req === (m_pend && !m_mask), "R7 model irq_req", int'(irq_req), int'(m_pend && !m_mask));
      chk(pin_level === m_s2, "R3 model pin_level", int'(pin_level), int'(m_s2));
      chk(bus_rdata === exp_rd, "R8 model rdata", int'(bus_rdata), int'(exp_rd));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = 8'h00;
  endtask

  task automatic vf();
    @(negedge clk);
    vec_fetch = 1;
    @(negedge clk);
    vec_fetch = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    irq_pin_n = v;
  endtask

  function automatic bit pend_of(input logic [7:0] d);
    return d[3];
  endfunction

  initial begin
    #2_000_000ns;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 0; irq_pin_n = 1; bus_sel = 0; bus_we = 0; bus_wdata = 0; vec_fetch = 0;
    cyc(3);
    // R1 reset state
    rd(r);
    chk(r == 8'h00, "R1 rdata in reset", r, 0);
    chk(irq_req == 0 && pin_level == 1, "R1 outputs in reset", {irq_req, pin_level}, 1);
    @(negedge clk); rst_n = 1;
    cyc(4);
    rd(r);
    chk(r == 8'h00, "R1 rdata after release", r, 0);

    // R2 / R3 latency
    pin(0);
    @(negedge clk); #1;
    chk(pin_level == 1, "R3 level one edge later", pin_level, 1);
    @(negedge clk); #1;
    chk(pin_level == 0, "R3 level two edges later", pin_level, 0);
    chk(irq_req == 0, "R2 not yet pending", irq_req, 0);
    @(negedge clk); #1;
    chk(irq_req == 1, "R2 pending at k+2", irq_req, 1);

    // R9 write with ack bit clear
    wr(8'h00);
    rd(r);
    chk(pend_of(r) == 1, "R9 no-ack write keeps flag", r[3], 1);
    // R4 vector fetch clears in edge mode with pin low
    vf();
    rd(r);
    chk(pend_of(r) == 0, "R4 vector fetch clears", r[3], 0);
    pin(1); cyc(4); pin(0); cyc(4);
    wr(8'h04);
    rd(r);
    chk(pend_of(r) == 0, "R4 software ack clears", r[3], 0);

    // R5 level mode, ack while low
    pin(1); cyc(4);
    wr(8'h01);
    pin(0); cyc(4);
    vf();
    cyc(3);
    rd(r);
    chk(pend_of(r) == 1, "R5 held while pin low", r[3], 1);
    pin(1);
    @(negedge clk); @(negedge clk); #1;
    chk(irq_req == 1, "R5 not yet cleared", irq_req, 1);
    @(negedge clk); #1;
    chk(irq_req == 0, "R5 cleared after pin high", irq_req, 0);

    // R6 pin high first, then ack
    pin(0); cyc(4);
    pin(1); cyc(4);
    rd(r);
    chk(pend_of(r) == 1, "R6 no ack keeps flag", r[3], 1);
    wr(8'h05);
    rd(r);
    chk(r == 8'h01, "R6 ack clears, mode kept", r, 8'h01);

    // R7 mask
    pin(0); cyc(4);
    wr(8'h03);
    #1 chk(irq_req == 0, "R7 masked request", irq_req, 0);
    rd(r);
    chk(r == 8'h0B, "R7 flag kept under mask", r, 8'h0B);
    wr(8'h01);
    #1 chk(irq_req == 1, "R7 request after unmask", irq_req, 1);
    pin(1); cyc(3); vf(); cyc(1);

    // R10 edge and ack in same cycle (edge mode)
    wr(8'h00);
    pin(0); cyc(4); pin(1); cyc(4);
    chk(irq_req == 1, "R10 setup pending", irq_req, 1);
    pin(0);
    @(negedge clk);
    @(negedge clk); vec_fetch = 1;
    @(negedge clk); vec_fetch = 0;
    #1 chk(irq_req == 1, "R10 set wins over ack", irq_req, 1);
    pin(1); cyc(3); vf(); cyc(1);
    chk(irq_req == 0, "R10 later ack clears", irq_req, 0);

    // R12 ack with nothing pending is not remembered (level mode)
    wr(8'h01);
    vf();
    pin(0); cyc(4);
    pin(1); cyc(4);
    rd(r);
    chk(pend_of(r) == 1, "R12 stale ack ignored", r[3], 1);
    vf(); cyc(1);
    chk(irq_req == 0, "R12 fresh ack clears", irq_req, 0);

    // R8 layout
    wr(8'hFF);
    rd(r);
    chk(r == 8'h03, "R8 reserved and ack read zero", r, 8'h03);
    @(negedge clk); #1;
    chk(bus_rdata == 8'h00, "R8 unselected reads zero", bus_rdata, 0);
    wr(8'h01);

    // R11 reset with pin low
    pin(0); cyc(4);
    chk(irq_req == 1, "R11 setup pending", irq_req, 1);
    @(negedge clk); rst_n = 0;
    bus_sel = 1; #1;
    chk(bus_rdata == 8'h00, "R11 flag and mode cleared", bus_rdata, 0);
    chk(irq_req == 0, "R11 request removed", irq_req, 0);
    bus_sel = 0;
    cyc(2); irq_pin_n = 1;
    @(negedge clk); rst_n = 1;
    cyc(5);
    rd(r);
    chk(r == 8'h00, "R11 state after release", r, 0);

    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule